// File: doc/BRIEF.md
# Page-Latched Data EEPROM Controller

This block manages a small byte-wide nonvolatile data array. A control/status register sets the mode. In read mode, a bus read of the array area returns the stored byte combinationally. In latch mode, bus writes do not reach the array. Each write goes into one slot of a sixteen-byte page buffer, and the low four address bits choose the slot. The row part of the most recent write sets the target row.

Software starts a commit by setting the commit bit. A timed sequence then copies every loaded slot into the chosen row, one slot per clock. At the end of the sequence the hardware clears the commit and latch-mode bits together, empties the page, and raises an interrupt request if interrupts are enabled. An acknowledge strobe clears the request.

A slot written twice before it is emptied holds the AND of both values. The page is emptied at the end of a commit and whenever software drops the latch-mode bit. The array is a register file sized by a parameter. After power-up it holds 0xFF, and reset does not change it.

Top module: `nvm_page_ctrl`

## Requirements
- R1: With the commit bit clear, `rd_data` equals the array byte at `bus_addr` in the same cycle. An unprogrammed byte reads 0xFF.
- R2: With latch mode set (control bit 0) and no commit running, a pulse on `area_wr` loads `bus_wdata` into page slot `bus_addr[3:0]`. The array is not changed until a commit.
- R3: A commit writes only the slots loaded since the page was last emptied. Every other byte of the target row keeps its value.
- R4: The target row is `bus_addr[ADDR_W-1:4]` of the last latch-mode write before the commit. Slots loaded under another row land in that last row.
- R5: A slot written again before it is emptied holds the bitwise AND of its old value and the new data.
- R6: Writing the control register with latch mode going from 1 to 0 empties the page. Slots loaded before that are not programmed by a later commit.
- R7: Writing bit 1 (commit) while latch mode is already set starts a commit. The commit lasts exactly PROG_CYCLES clocks. On the last clock, bits 1 and 0 both return to 0 and the page is emptied.
- R8: When a commit ends with bit 2 (interrupt enable) set, `irq` goes to 1. When bit 2 is clear, `irq` stays 0. `irq_ack` returns `irq` to 0.
- R9: While a commit runs, `area_wr` is ignored and control writes cannot clear bits 1 or 0. `rd_data` returns 0xFF.
- R10: A commit request made while latch mode is 0 is ignored. `area_wr` while latch mode is 0 loads nothing.
- R11: Reset clears the control bits, the page, its loaded flags and `irq`. The array contents are kept. `csr_rdata` is {5'b0, interrupt enable, commit, latch mode}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address within the array area |
| bus_wdata | input | 8 | Write data for the array area |
| area_wr | input | 1 | Write strobe for the array area |
| rd_data | output | 8 | Read data for the array area (combinational) |
| csr_wr | input | 1 | Control register write strobe |
| csr_wdata | input | 8 | Control register write data |
| csr_rdata | output | 8 | Control register read value |
| irq | output | 1 | Commit-done interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge strobe |

## Verification
Commits are tried with two slots in one row, and with two writes to one slot followed by a write in another row. These cases separate per-slot masking from whole-row writes, AND-merge from overwrite, and last-row targeting from first-row targeting. Further patterns cover these cases:
- dropping latch mode between loads, which tells page emptying apart from carry-over;
- requesting a commit from read mode;
- writing and clearing the control bits while a commit runs.

The interrupt is checked with the enable bit set and with it clear. Directed tests pin the commit length to the exact clock and show that reset keeps the array but drops a loaded page.

// File: rtl/nvm_page_pkg.sv
package nvm_page_pkg;
  localparam int PAGE_BYTES = 16;
  localparam int IDX_W      = 4;
  localparam int CSR_LATCH  = 0;
  localparam int CSR_COMMIT = 1;
  localparam int CSR_IE     = 2;
  localparam logic [7:0] BLANK_BYTE = 8'hFF;
endpackage

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  // power-up content: erased cells
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = nvm_page_pkg::BLANK_BYTE;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/nvm_page_buf.sv
module nvm_page_buf
  import nvm_page_pkg::*;
#(
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic [IDX_W-1:0] cap_idx,
  input  logic [ROW_W-1:0] cap_row,
  input  logic [7:0]       cap_data,
  input  logic             clr,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_byte,
  output logic             rd_valid,
  output logic [ROW_W-1:0] row
);
  logic [7:0]            slot [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] loaded;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      loaded <= '0;
    end else if (cap) begin
      loaded[cap_idx] <= 1'b1;
    end
    if (rst) begin
      row <= '0;
    end else if (cap) begin
      row <= cap_row;
    end
  end

  generate
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (cap && cap_idx == IDX_W'(g)) begin
          slot[g] <= loaded[g] ? (slot[g] & cap_data) : cap_data;
        end
      end
    end
  endgenerate

  assign rd_byte  = slot[rd_idx];
  assign rd_valid = loaded[rd_idx];

  // R6 / R7: an empty request leaves no slot marked loaded
  p_clr_empties_r6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (loaded == '0));
  // R2: a capture marks its slot loaded
  p_cap_marks_r2: assert property (@(posedge clk) disable iff (rst)
    (cap && !clr) |=> loaded[$past(cap_idx)]);
endmodule

// File: rtl/nvm_prog_seq.sv
module nvm_prog_seq
  import nvm_page_pkg::*;
#(
  parameter int PROG_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csr_wr,
  input  logic [7:0]       csr_wdata,
  input  logic             irq_ack,
  output logic             latch_q,
  output logic             commit_q,
  output logic             ie_q,
  output logic             irq,
  output logic             step_en,
  output logic [IDX_W-1:0] step_idx,
  output logic             clr_page
);
  localparam int CNT_W = $clog2(PROG_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

  generate
    if (PROG_CYCLES < PAGE_BYTES) begin : g_bad_len
      $error("PROG_CYCLES must cover one clock per page slot");
    end
  endgenerate

  logic [CNT_W-1:0] cnt;
  logic done, start, fall;

  assign done  = commit_q && (cnt == LAST);
  assign start = !commit_q && csr_wr && csr_wdata[CSR_COMMIT] && latch_q;
  assign fall  = !commit_q && csr_wr && !start && latch_q && !csr_wdata[CSR_LATCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q  <= 1'b0;
      commit_q <= 1'b0;
      ie_q     <= 1'b0;
      irq      <= 1'b0;
      cnt      <= '0;
    end else begin
      if (irq_ack) irq <= 1'b0;
      if (csr_wr) ie_q <= csr_wdata[CSR_IE];
      if (commit_q) begin
        if (done) begin
          commit_q <= 1'b0;
          latch_q  <= 1'b0;
          cnt      <= '0;
          if (ie_q) irq <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (start) begin
        commit_q <= 1'b1;
        cnt      <= '0;
      end else if (csr_wr) begin
        latch_q <= csr_wdata[CSR_LATCH];
      end
    end
  end

  assign step_en  = commit_q && (32'(cnt) < 32'(PAGE_BYTES));
  assign step_idx = cnt[IDX_W-1:0];
  assign clr_page = done || fall;

  // R7: commit is only ever active inside latch mode
  p_commit_in_latch_r7: assert property (@(posedge clk) disable iff (rst)
    commit_q |-> latch_q);
  // R7: commit and latch mode drop together
  p_drop_together_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(commit_q) |-> $fell(latch_q));
  // R7: timer never passes the commit length
  p_timer_bound_r7: assert property (@(posedge clk) disable iff (rst)
    32'(cnt) < 32'(PROG_CYCLES));
  // R8: a request only appears as a commit finishes
  p_irq_at_end_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(commit_q) && !commit_q));
  // R10: a commit begins only from latch mode
  p_commit_needs_latch_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(commit_q) |-> $past(latch_q));
endmodule

// File: rtl/nvm_page_ctrl.sv
module nvm_page_ctrl
  import nvm_page_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PROG_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              area_wr,
  output logic [7:0]        rd_data,
  input  logic              csr_wr,
  input  logic [7:0]        csr_wdata,
  output logic [7:0]        csr_rdata,
  output logic              irq,
  input  logic              irq_ack
);
  localparam int ROW_W = ADDR_W - IDX_W;

  logic             latch_q, commit_q, ie_q;
  logic             step_en, clr_page, slot_valid;
  logic [IDX_W-1:0] step_idx;
  logic [7:0]       slot_byte, arr_rdata;
  logic [ROW_W-1:0] row;
  logic             cap, arr_we;

  nvm_prog_seq #(.PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .irq_ack(irq_ack), .latch_q(latch_q), .commit_q(commit_q), .ie_q(ie_q),
    .irq(irq), .step_en(step_en), .step_idx(step_idx), .clr_page(clr_page)
  );

  assign cap = area_wr && latch_q && !commit_q;

  nvm_page_buf #(.ROW_W(ROW_W)) u_buf (
    .clk(clk), .rst(rst), .cap(cap), .cap_idx(bus_addr[IDX_W-1:0]),
    .cap_row(bus_addr[ADDR_W-1:IDX_W]), .cap_data(bus_wdata), .clr(clr_page),
    .rd_idx(step_idx), .rd_byte(slot_byte), .rd_valid(slot_valid), .row(row)
  );

  assign arr_we = step_en && slot_valid;

  nvm_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .we(arr_we), .waddr({row, step_idx}), .wdata(slot_byte),
    .raddr(bus_addr), .rdata(arr_rdata)
  );

  assign rd_data   = commit_q ? BLANK_BYTE : arr_rdata;
  assign csr_rdata = {5'b0, ie_q, commit_q, latch_q};

  // R3: the array is only written during a commit
  p_write_in_commit_r3: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> commit_q);
endmodule

// File: tb/nvm_page_ctrl_bench.sv
module nvm_page_ctrl_bench;
  localparam int AW = 6;
  localparam int PC = 20;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata;
  logic          area_wr;
  logic [7:0]    rd_data;
  logic          csr_wr;
  logic [7:0]    csr_wdata;
  logic [7:0]    csr_rdata;
  logic          irq;
  logic          irq_ack;

  always #10 clk = ~clk;

  nvm_page_ctrl #(.ADDR_W(AW), .PROG_CYCLES(PC)) u_nvm_page_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .area_wr(area_wr), .rd_data(rd_data), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq), .irq_ack(irq_ack)
  );

  typedef enum logic [2:0] {
    OP_WR, OP_RD, OP_CW, OP_CR, OP_WT, OP_IRQ, OP_ACK
  } op_e;
  typedef struct packed {
    op_e        op;
    logic [5:0] a;
    logic [7:0] d;
    logic [3:0] req;
  } vec_t;

  // control bits: [0] latch mode, [1] commit, [2] irq enable
  localparam int NV = 54;
  localparam vec_t VEC [NV] = '{
    '{OP_CR,  6'h00, 8'h00, 4'd11}, // R11 reset value
    '{OP_RD,  6'h05, 8'hFF, 4'd1 }, // R1 blank read
    '{OP_CW,  6'h00, 8'h01, 4'd2 },
    '{OP_WR,  6'h13, 8'hA5, 4'd2 },
    '{OP_WR,  6'h1A, 8'h3C, 4'd2 },
    '{OP_RD,  6'h13, 8'hFF, 4'd2 }, // R2 not in array yet
    '{OP_CR,  6'h00, 8'h01, 4'd2 },
    '{OP_CW,  6'h00, 8'h07, 4'd7 },
    '{OP_CR,  6'h00, 8'h07, 4'd7 },
    '{OP_WT,  6'h00, 8'h00, 4'd7 },
    '{OP_CR,  6'h00, 8'h04, 4'd7 }, // R7 both bits dropped
    '{OP_IRQ, 6'h00, 8'h01, 4'd8 },
    '{OP_ACK, 6'h00, 8'h00, 4'd8 },
    '{OP_IRQ, 6'h00, 8'h00, 4'd8 }, // R8 ack clears
    '{OP_RD,  6'h13, 8'hA5, 4'd3 },
    '{OP_RD,  6'h1A, 8'h3C, 4'd3 },
    '{OP_RD,  6'h14, 8'hFF, 4'd3 }, // R3 unloaded slot untouched
    '{OP_CW,  6'h00, 8'h01, 4'd5 },
    '{OP_WR,  6'h02, 8'hF0, 4'd5 },
    '{OP_WR,  6'h02, 8'h3C, 4'd5 },
    '{OP_WR,  6'h25, 8'h11, 4'd4 },
    '{OP_CW,  6'h00, 8'h03, 4'd4 },
    '{OP_WT,  6'h00, 8'h00, 4'd4 },
    '{OP_IRQ, 6'h00, 8'h00, 4'd8 }, // R8 no irq when disabled
    '{OP_RD,  6'h22, 8'h30, 4'd5 }, // R5 AND merge, R4 last row
    '{OP_RD,  6'h25, 8'h11, 4'd4 },
    '{OP_RD,  6'h02, 8'hFF, 4'd4 }, // R4 first row untouched
    '{OP_CW,  6'h00, 8'h01, 4'd6 },
    '{OP_WR,  6'h31, 8'h00, 4'd6 },
    '{OP_CW,  6'h00, 8'h00, 4'd6 },
    '{OP_CW,  6'h00, 8'h01, 4'd6 },
    '{OP_WR,  6'h36, 8'h77, 4'd6 },
    '{OP_CW,  6'h00, 8'h03, 4'd6 },
    '{OP_WT,  6'h00, 8'h00, 4'd6 },
    '{OP_RD,  6'h31, 8'hFF, 4'd6 }, // R6 dropped slot not programmed
    '{OP_RD,  6'h36, 8'h77, 4'd6 },
    '{OP_CW,  6'h00, 8'h02, 4'd10},
    '{OP_CR,  6'h00, 8'h00, 4'd10}, // R10 commit refused
    '{OP_WR,  6'h36, 8'h00, 4'd10},
    '{OP_CW,  6'h00, 8'h01, 4'd10},
    '{OP_CW,  6'h00, 8'h03, 4'd10},
    '{OP_WT,  6'h00, 8'h00, 4'd10},
    '{OP_RD,  6'h36, 8'h77, 4'd10}, // R10 nothing was captured
    '{OP_CW,  6'h00, 8'h01, 4'd9 },
    '{OP_WR,  6'h1A, 8'h0F, 4'd9 },
    '{OP_CW,  6'h00, 8'h03, 4'd9 },
    '{OP_RD,  6'h1A, 8'hFF, 4'd9 }, // R9 busy read
    '{OP_WR,  6'h1B, 8'h00, 4'd9 },
    '{OP_CW,  6'h00, 8'h00, 4'd9 },
    '{OP_CR,  6'h00, 8'h03, 4'd9 }, // R9 clear attempt ignored
    '{OP_WT,  6'h00, 8'h00, 4'd9 },
    '{OP_CR,  6'h00, 8'h00, 4'd9 },
    '{OP_RD,  6'h1A, 8'h0F, 4'd9 },
    '{OP_RD,  6'h1B, 8'hFF, 4'd9 }  // R9 busy write ignored
  };

  int n_chk  = 0;
  int n_fail = 0;

  task automatic check(input string what, input int req, input logic [7:0] act,
                       input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; area_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    area_wr = 1'b0;
  endtask

  task automatic ctl_write(input logic [7:0] d);
    csr_wdata = d; csr_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic wait_clocks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_wdata = '0; area_wr = 1'b0;
    csr_wr = 1'b0; csr_wdata = '0; irq_ack = 1'b0;
    wait_clocks(3);
    rst = 1'b0;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      case (VEC[k].op)
        OP_WR:  bus_write(VEC[k].a, VEC[k].d);
        OP_CW:  ctl_write(VEC[k].d);
        OP_WT:  wait_clocks(PC);
        OP_ACK: begin
          irq_ack = 1'b1; @(posedge clk); @(negedge clk); irq_ack = 1'b0;
        end
        OP_RD: begin
          bus_addr = VEC[k].a; #1;
          check($sformatf("vec %0d read", k), int'(VEC[k].req), rd_data, VEC[k].d);
        end
        OP_CR:  check($sformatf("vec %0d ctl", k), int'(VEC[k].req), csr_rdata, VEC[k].d);
        OP_IRQ: check($sformatf("vec %0d irq", k), int'(VEC[k].req), {7'b0, irq}, VEC[k].d);
        default: ;
      endcase
    end

    // R7: exact commit length
    ctl_write(8'h01);
    bus_write(6'h3F, 8'h5A);
    ctl_write(8'h07);
    wait_clocks(PC - 1);
    check("still busy one clock before end", 7, csr_rdata, 8'h07);
    wait_clocks(1);
    check("bits dropped on last clock", 7, csr_rdata, 8'h04);
    check("irq at end", 8, {7'b0, irq}, 8'h01);

    // R11: reset with a pending irq and a loaded page
    ctl_write(8'h01);
    bus_write(6'h00, 8'h12);
    rst = 1'b1; wait_clocks(1); rst = 1'b0;
    check("ctl after reset", 11, csr_rdata, 8'h00);
    check("irq after reset", 11, {7'b0, irq}, 8'h00);
    bus_addr = 6'h3F; #1;
    check("array kept over reset", 11, rd_data, 8'h5A);
    ctl_write(8'h01);
    ctl_write(8'h03);
    wait_clocks(PC);
    bus_addr = 6'h00; #1;
    check("page dropped by reset", 11, rd_data, 8'hFF);

    finish_run();
  end
endmodule